// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives a successive-approximation converter through a run of conversions on one selected input channel. It divides the bus clock into a conversion clock and holds every conversion for a fixed number of conversion-clock cycles. That number is an optional discharge phase, then a sample phase picked by a 3-bit code, then a resolution phase of 15 cycles. Conversions follow each other with no gap. Each result goes into one of eight result registers, and each register has a completion flag.

A write on the configuration strobe latches the settings and starts a sequence at once. The results are placed in one of two ways. In indexed placement, conversion k lands in register k. In ring placement, results go to consecutive registers, and the pointer wraps and survives from one sequence to the next. In single mode the controller goes idle after the last conversion. In continuous mode it starts the next sequence in the same cycle and keeps going until a stop strobe arrives.

The comparator and DAC sit outside the block. The controller reaches them with a one-cycle start pulse and a channel number. It takes the result word in the cycle the converter raises done.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, seq_done and ana_start are 0, every cc_flags bit is 0, every result register reads 0 and ana_channel is 0.
- R2: Let DIV = 2*(cfg_prescale+1) and N = D + S + 15, where D is 2 when cfg_discharge is 1 and 0 otherwise, and S is the sample length. Each conversion lasts DIV*N bus cycles. ana_start pulses for one cycle after the start edge and after each conversion that is not the last of a single sequence.
- R3: Sample-code mapping. cfg_sample_code 0..7 selects S = 4, 6, 8, 10, 12, 16, 20 and 24 conversion-clock cycles, in that order.
- R4: With cfg_fifo = 0, conversion k (counting from 0) writes register k. A sequence runs cfg_seq_len conversions, and the value 0 means 8.
- R5: With cfg_fifo = 1, results go to consecutive registers. The pointer wraps from 7 to 0 and is kept across sequences.
- R6: A start with cfg_fifo = 0 resets the write pointer to register 0.
- R7: A result write sets that register's bit in cc_flags. A rd_en pulse clears the flag of the register at rd_idx. If a write and a clear hit the same register in one cycle, the write wins.
- R8: seq_done is a one-cycle pulse. It appears in the cycle after the last result of a sequence is written. In single mode, busy falls at the same time.
- R9: In continuous mode the next sequence starts in the same cycle that seq_done rises, with no idle cycle, and this repeats until stopped.
- R10: The cycle after a stop pulse, busy is 0. After that, no further ana_start pulse appears and no further result is written.
- R11: The stored result is the ana_result word that was present while ana_done was high during that conversion.
- R12: ana_channel holds the channel latched at the start. Changes on cfg_channel during a sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Latch configuration and start a sequence |
| cfg_prescale | input | PRS_W | Prescaler; conversion clock = bus / (2*(value+1)) |
| cfg_sample_code | input | 3 | Sample length code |
| cfg_discharge | input | 1 | Add the discharge phase |
| cfg_seq_len | input | log2(NREG) | Conversions per sequence, 0 means NREG |
| cfg_fifo | input | 1 | 1 selects ring placement |
| cfg_continuous | input | 1 | 1 restarts sequences without end |
| cfg_channel | input | CH_W | Channel to convert |
| stop | input | 1 | Halt the controller |
| ana_start | output | 1 | Start pulse to the analog core |
| ana_channel | output | CH_W | Channel for the analog core |
| ana_done | input | 1 | Analog core result valid |
| ana_result | input | RES_W | Analog core result word |
| rd_en | input | 1 | Read strobe, clears the addressed flag |
| rd_idx | input | log2(NREG) | Result register index |
| rd_data | output | RES_W | Content of the addressed register |
| cc_flags | output | NREG | Per-register completion flags |
| seq_done | output | 1 | Sequence-complete pulse |
| busy | output | 1 | A sequence is running |

## Verification
Each conversion result is due exactly DIV*N bus edges after the edge at which its ana_start was launched. The next ana_start, the flag bit and, for the last conversion, seq_done all become visible after that same edge. A behavioural model in the bench counts bus edges from each start strobe and predicts every output for every cycle. Inputs are driven 2 ns after a rising edge, and the compare runs at the falling edge, once all registers have settled. Separate checks measure the negedge count from a start to seq_done, and the gap between consecutive pulses, against the R2/R3 formula.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int RES_CYC    = 15;
   localparam int SAMPLE_MAX = 24;

   function automatic logic [4:0] sample_cycles(input logic [2:0] code);
      logic [4:0] s;
      case (code)
         3'd0:    s = 5'd4;
         3'd1:    s = 5'd6;
         3'd2:    s = 5'd8;
         3'd3:    s = 5'd10;
         3'd4:    s = 5'd12;
         3'd5:    s = 5'd16;
         3'd6:    s = 5'd20;
         default: s = 5'd24;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
   parameter int PRS_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [PRS_W-1:0] prs,
   output logic             tick
);
   logic [PRS_W:0] cnt;
   logic [PRS_W:0] limit;

   assign limit = {prs, 1'b1};
   assign tick  = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr || !run)    cnt <= '0;
      else if (cnt == limit)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [CW-1:0] len,
   output logic          conv_end
);
   logic [CW-1:0] cnt;

   assign conv_end = tick && (cnt == len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (clr)      cnt <= '0;
      else if (conv_end) cnt <= '0;
      else if (tick)     cnt <= cnt + 1'b1;
   end

   AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < len); // R2

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NREG  = 8,
   parameter int RES_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [$clog2(NREG)-1:0] wr_idx,
   input  logic [RES_W-1:0]        wr_data,
   input  logic                    rd_en,
   input  logic [$clog2(NREG)-1:0] rd_idx,
   output logic [RES_W-1:0]        rd_data,
   output logic [NREG-1:0]         flags
);
   localparam int IDX_W = $clog2(NREG);

   logic [RES_W-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      logic [RES_W-1:0] data_r;
      logic             flag_r;
      logic             hit_w;
      logic             hit_r;

      assign hit_w = wr_en && (wr_idx == IDX_W'(i));
      assign hit_r = rd_en && (rd_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_r <= '0;
            flag_r <= 1'b0;
         end else begin
            if (hit_w)      data_r <= wr_data;
            if (hit_w)      flag_r <= 1'b1;
            else if (hit_r) flag_r <= 1'b0;
         end
      end

      assign regs[i]  = data_r;
      assign flags[i] = flag_r;
   end

   assign rd_data = regs[rd_idx];

   AST_FLAG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> flags[$past(wr_idx)]); // R7

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NREG          = 8,
   parameter int RES_W         = 12,
   parameter int CH_W          = 4,
   parameter int PRS_W         = 5,
   parameter int DISCHARGE_CYC = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic [PRS_W-1:0]        cfg_prescale,
   input  logic [2:0]              cfg_sample_code,
   input  logic                    cfg_discharge,
   input  logic [$clog2(NREG)-1:0] cfg_seq_len,
   input  logic                    cfg_fifo,
   input  logic                    cfg_continuous,
   input  logic [CH_W-1:0]         cfg_channel,
   input  logic                    stop,
   output logic                    ana_start,
   output logic [CH_W-1:0]         ana_channel,
   input  logic                    ana_done,
   input  logic [RES_W-1:0]        ana_result,
   input  logic                    rd_en,
   input  logic [$clog2(NREG)-1:0] rd_idx,
   output logic [RES_W-1:0]        rd_data,
   output logic [NREG-1:0]         cc_flags,
   output logic                    seq_done,
   output logic                    busy
);
   localparam int IDX_W = $clog2(NREG);
   localparam int N_MAX = DISCHARGE_CYC + SAMPLE_MAX + RES_CYC;
   localparam int CW    = $clog2(N_MAX + 1);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two, at least 2");
   end
   if (RES_W < 1 || CH_W < 1 || PRS_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end
   if (DISCHARGE_CYC < 0) begin : g_bad_dis
      $error("DISCHARGE_CYC must not be negative");
   end

   logic [PRS_W-1:0] prs_q;
   logic [2:0]       code_q;
   logic             dis_q, fifo_q, cont_q, busy_q;
   logic [IDX_W:0]   len_q, k_q;
   logic [IDX_W-1:0] ptr_q;
   logic [RES_W-1:0] res_q;
   logic [CH_W-1:0]  chan_q;
   logic [CW-1:0]    conv_len;
   logic             tick, conv_end, wr_en;

   assign conv_len = CW'(dis_q ? DISCHARGE_CYC : 0) + CW'(sample_cycles(code_q))
                   + CW'(RES_CYC);
   assign wr_en    = conv_end && !stop && !cfg_wr;

   adc_clk_div #(.PRS_W(PRS_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .run(busy_q), .prs(prs_q), .tick(tick)
   );

   adc_conv_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(cfg_wr || stop), .tick(tick),
      .len(conv_len), .conv_end(conv_end)
   );

   adc_result_bank #(.NREG(NREG), .RES_W(RES_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr_q), .wr_data(res_q),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .flags(cc_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prs_q <= '0; code_q <= '0; dis_q <= 1'b0; fifo_q <= 1'b0; cont_q <= 1'b0;
         len_q <= '0; k_q <= '0; ptr_q <= '0; res_q <= '0; chan_q <= '0;
         busy_q <= 1'b0; ana_start <= 1'b0; seq_done <= 1'b0;
      end else begin
         ana_start <= 1'b0;
         seq_done  <= 1'b0;
         if (ana_done) res_q <= ana_result;
         if (stop) begin
            busy_q <= 1'b0;
         end else if (cfg_wr) begin
            prs_q     <= cfg_prescale;
            code_q    <= cfg_sample_code;
            dis_q     <= cfg_discharge;
            fifo_q    <= cfg_fifo;
            cont_q    <= cfg_continuous;
            chan_q    <= cfg_channel;
            len_q     <= (cfg_seq_len == '0) ? (IDX_W+1)'(NREG) : {1'b0, cfg_seq_len};
            k_q       <= '0;
            busy_q    <= 1'b1;
            ana_start <= 1'b1;
            if (!cfg_fifo) ptr_q <= '0;
         end else if (conv_end) begin
            ptr_q <= ptr_q + 1'b1;
            if (k_q == len_q - 1'b1) begin
               seq_done <= 1'b1;
               k_q      <= '0;
               if (cont_q) begin
                  ana_start <= 1'b1;
                  if (!fifo_q) ptr_q <= '0;
               end else begin
                  busy_q <= 1'b0;
               end
            end else begin
               k_q       <= k_q + 1'b1;
               ana_start <= 1'b1;
            end
         end
      end
   end

   assign busy        = busy_q;
   assign ana_channel = chan_q;

   AST_START_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ana_start |-> busy); // R10
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done); // R8
   AST_SINGLE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !cont_q) |-> !busy); // R8
   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!busy && !ana_start)); // R10

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 0, cfg_discharge = 0, cfg_fifo = 0, cfg_continuous = 0, stop = 0;
   logic [4:0]  cfg_prescale = 0;
   logic [2:0]  cfg_sample_code = 0, cfg_seq_len = 0, rd_idx = 0;
   logic [3:0]  cfg_channel = 0, ana_channel;
   logic        ana_start, ana_done = 0, rd_en = 0, seq_done, busy;
   logic [11:0] ana_result = 0, rd_data;
   logic [7:0]  cc_flags;

   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   adc_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_prescale(cfg_prescale),
      .cfg_sample_code(cfg_sample_code), .cfg_discharge(cfg_discharge),
      .cfg_seq_len(cfg_seq_len), .cfg_fifo(cfg_fifo), .cfg_continuous(cfg_continuous),
      .cfg_channel(cfg_channel), .stop(stop), .ana_start(ana_start),
      .ana_channel(ana_channel), .ana_done(ana_done), .ana_result(ana_result),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .cc_flags(cc_flags),
      .seq_done(seq_done), .busy(busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int samp(input int code);
      int t[8] = '{4, 6, 8, 10, 12, 16, 20, 24};
      return t[code];
   endfunction

   // analog core stand-in: done 3 cycles after start
   int given = 0, next_val = 12'h0A5, pend = 0;
   int given_q[$];
   always @(negedge clk) begin
      ana_done <= 1'b0;
      if (pend > 0) begin
         pend--;
         if (pend == 0) begin
            ana_done   <= 1'b1;
            ana_result <= 12'(next_val);
            given      = next_val;
            given_q.push_back(next_val);
            next_val   = (next_val + 12'h137) & 12'hFFF;
         end
      end
      if (ana_start) pend = 3;
   end

   // behavioural reference model
   int m_div = 2, m_n = 19, m_len = 1, m_cyc = 0, m_k = 0, m_ptr = 0, m_chan = 0;
   bit m_fifo = 0, m_cont = 0, m_busy = 0, m_start = 0, m_sdone = 0;
   bit [7:0] m_flags = 0;
   int m_res[8] = '{default: 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_start = 0; m_sdone = 0; m_flags = 0; m_ptr = 0; m_chan = 0;
         foreach (m_res[i]) m_res[i] = 0;
      end else begin
         m_start = 0; m_sdone = 0;
         if (rd_en) m_flags[rd_idx] = 1'b0;
         if (stop) m_busy = 0;
         else if (cfg_wr) begin
            m_div  = 2 * (int'(cfg_prescale) + 1);
            m_n    = (cfg_discharge ? 2 : 0) + samp(int'(cfg_sample_code)) + 15;
            m_len  = (cfg_seq_len == 0) ? 8 : int'(cfg_seq_len);
            m_fifo = cfg_fifo; m_cont = cfg_continuous; m_chan = int'(cfg_channel);
            m_busy = 1; m_cyc = 0; m_k = 0; m_start = 1;
            if (!cfg_fifo) m_ptr = 0;
         end else if (m_busy) begin
            m_cyc++;
            if (m_cyc == m_div * m_n) begin
               m_cyc = 0;
               m_res[m_ptr] = given;
               m_flags[m_ptr] = 1'b1;
               m_ptr = (m_ptr + 1) % 8;
               m_k++;
               if (m_k == m_len) begin
                  m_sdone = 1; m_k = 0;
                  if (m_cont) begin
                     m_start = 1;
                     if (!m_fifo) m_ptr = 0;
                  end else m_busy = 0;
               end else m_start = 1;
            end
         end
      end
   end

   always @(negedge clk) if (rst_n) begin
      chk("R2 ana_start", int'(ana_start), int'(m_start));
      chk("R8 busy", int'(busy), int'(m_busy));
      chk("R8 seq_done", int'(seq_done), int'(m_sdone));
      chk("R7 cc_flags", int'(cc_flags), int'(m_flags));
      chk("R4 rd_data", int'(rd_data), m_res[rd_idx]);
      chk("R12 ana_channel", int'(ana_channel), m_chan);
   end

   task automatic start_seq(input int prs, input int code, input int dis, input int len,
                            input int fifo, input int cont, input int chan);
      @(posedge clk); #2;
      cfg_prescale = 5'(prs); cfg_sample_code = 3'(code); cfg_discharge = dis[0];
      cfg_seq_len = 3'(len); cfg_fifo = fifo[0]; cfg_continuous = cont[0];
      cfg_channel = 4'(chan); cfg_wr = 1;
      @(posedge clk); #2; cfg_wr = 0;
   endtask

   task automatic wait_sdone(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!seq_done);
   endtask

   task automatic clear_all();
      for (int i = 0; i < 8; i++) begin
         @(posedge clk); #2; rd_idx = 3'(i); rd_en = 1;
      end
      @(posedge clk); #2; rd_en = 0; rd_idx = 0;
   endtask

   task automatic do_stop();
      @(posedge clk); #2; stop = 1;
      @(posedge clk); #2; stop = 0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int n, n2, cnt;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 busy", int'(busy), 0); chk("R1 flags", int'(cc_flags), 0);
      chk("R1 seq_done", int'(seq_done), 0); chk("R1 ana_start", int'(ana_start), 0);
      chk("R1 rd_data", int'(rd_data), 0); chk("R1 channel", int'(ana_channel), 0);
      @(posedge clk); #2; rst_n = 1;

      // indexed placement, 3 conversions, code 0, DIV 2
      given_q.delete();
      start_seq(0, 0, 0, 3, 0, 0, 5);
      wait_sdone(n);
      chk("R2 R3 seq time code0", n - 1, 3 * 2 * (4 + 15));
      chk("R4 flags len3", int'(cc_flags), 8'b0000_0111);
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #2; rd_idx = 3'(i);
         @(negedge clk); chk("R11 stored result", int'(rd_data), given_q[i]);
      end
      @(posedge clk); #2; rd_idx = 1; rd_en = 1;
      @(posedge clk); #2; rd_en = 0;
      @(negedge clk); chk("R7 read clears flag", int'(cc_flags), 8'b0000_0101);

      // code 3, DIV 10, 2 conversions
      start_seq(4, 3, 0, 2, 0, 0, 2);
      wait_sdone(n);
      chk("R3 code3 sample 10", n - 1, 2 * 10 * 25);
      // discharge plus code 7, DIV 4, single
      start_seq(1, 7, 1, 1, 0, 0, 9);
      wait_sdone(n);
      chk("R2 discharge code7", n - 1, 4 * (2 + 24 + 15));
      start_seq(0, 5, 0, 1, 0, 0, 1);
      wait_sdone(n);
      chk("R3 code5 sample 16", n - 1, 2 * (16 + 15));

      // length 0 means 8
      clear_all();
      start_seq(0, 1, 0, 0, 0, 0, 3);
      wait_sdone(n);
      chk("R4 len0 time", n - 1, 8 * 2 * (6 + 15));
      chk("R4 len0 flags", int'(cc_flags), 8'hFF);

      // ring placement with wrap across sequences
      clear_all();
      start_seq(0, 0, 0, 5, 1, 0, 4);
      wait_sdone(n);
      chk("R5 ring first", int'(cc_flags), 8'b0001_1111);
      clear_all();
      start_seq(0, 0, 0, 5, 1, 0, 4);
      #1; cfg_channel = 4'd11;
      wait_sdone(n);
      chk("R5 ring wrap", int'(cc_flags), 8'b1110_0011);
      chk("R12 channel held", int'(ana_channel), 4);
      clear_all();
      start_seq(0, 0, 0, 2, 0, 0, 6);
      wait_sdone(n);
      chk("R6 pointer reset", int'(cc_flags), 8'b0000_0011);

      // continuous, with a held read of reg 0 (write wins)
      clear_all();
      start_seq(0, 0, 0, 2, 0, 1, 7);
      @(posedge clk); #2; rd_idx = 0; rd_en = 1;
      wait_sdone(n);
      wait_sdone(n2);
      chk("R9 back to back", n2, 2 * 2 * 19);
      @(negedge clk);
      chk("R9 still busy", int'(busy), 1);
      @(posedge clk); #2; rd_en = 0;
      do_stop();
      @(negedge clk); chk("R10 idle after stop", int'(busy), 0);
      cnt = 0;
      repeat (300) begin @(negedge clk); if (ana_start) cnt++; end
      chk("R10 no start after stop", cnt, 0);

      summary();
      $finish;
   end
endmodule